// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by reading two entries from a table held in memory. A requester offers the linear address with a valid/ready handshake. The walker forms the address of the directory entry from the directory base register and the top ten address bits, and reads that entry. It then forms the address of the table entry from the frame held in the directory entry and the middle ten address bits, and reads that entry too. Finally it joins the page frame from the table entry with the twelve offset bits.

Memory is reached through a single read port. The port issues one request pulse per level and accepts the response after any number of cycles. If either entry has its present bit clear, the walk ends with a fault that names the level. When the paging-enable input is low at acceptance, the walker skips memory entirely and returns the linear address unchanged. The base register and the enable bit must be set up before requests arrive; the walker samples both when it accepts a request. Only one request is in flight at a time.

Top module: `pgwalk_top`

## Requirements
- R1: With paging enabled, the first read after acceptance goes to `{cr_base[31:12], req_lin[31:22], 2'b00}`; the low 12 bits of `cr_base` are ignored.
- R2: When the directory entry is present (bit 0 = 1), the second read goes to `{dir_entry[31:12], req_lin[21:12], 2'b00}`.
- R3: When both entries are present, `rsp_phys` = `{tbl_entry[31:12], req_lin[11:0]}` with `rsp_fault` = 0.
- R4: A directory entry with bit 0 = 0 ends the walk with `rsp_fault` = 1, `rsp_fault_lvl` = 0 and `rsp_phys` = 0, and no table read is made.
- R5: A table entry with bit 0 = 0 ends the walk with `rsp_fault` = 1, `rsp_fault_lvl` = 1 and `rsp_phys` = 0.
- R6: With paging disabled at acceptance, no memory read is made, `rsp_valid` rises in the cycle after the accepting edge, and `rsp_phys` equals `req_lin` with `rsp_fault` = 0.
- R7: `req_ready` is low from the accepting edge until the response has been given. Requests offered during that time are ignored: they cause no read and no extra response.
- R8: Each level makes exactly one single-cycle `mem_rd_en` pulse and waits any number of cycles for `mem_rd_valid`. A walk with read latencies Ld and Lt responds Ld+Lt+4 edges after acceptance, and a directory fault responds Ld+2 edges after acceptance.
- R9: After reset, `req_ready` = 1, `rsp_valid` = 0 and `mem_rd_en` = 0.
- R10: `rsp_valid` is a one-cycle pulse. Changes to `cr_base` or `pg_en` after acceptance do not affect the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_lin | input | 32 | Linear address to translate |
| cr_base | input | 32 | Directory base register (bits 31:12 used) |
| pg_en | input | 1 | Paging enable |
| mem_rd_en | output | 1 | Read request pulse |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Result pulse |
| rsp_phys | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Page fault |
| rsp_fault_lvl | output | 1 | Faulting level: 0 directory, 1 table |

## Verification
On every cycle, the assertions check the following: the directory read address in the cycle after acceptance, the one-cycle bypass result, single-cycle read and response pulses, a zero physical address on faults, and the drop of `req_ready` after acceptance. The table-entry address, the final address composition, the exact response latency under mixed memory latencies, and the immunity to base and enable changes during a walk depend on memory contents and timing. Only the bench scenarios can show those, using their table images and read-latency settings.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned IDX_W    = 10;
  localparam int unsigned OFF_W    = 12;
  localparam int unsigned ENT_LG   = 2;
  localparam int unsigned FRAME_W  = ADDR_W - OFF_W;
  localparam int unsigned DIR_LSB  = OFF_W + IDX_W;
  localparam int unsigned TBL_LSB  = OFF_W;
  localparam int unsigned PRES_BIT = 0;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DIR   = 3'd1,
    ST_TBL   = 3'd2,
    ST_DONE  = 3'd3,
    ST_FAULT = 3'd4
  } walk_st_e;
endpackage

// File: rtl/pgwalk_ent_addr.sv
module pgwalk_ent_addr
  import pgwalk_pkg::*;
#(
  parameter int unsigned FRM_W = FRAME_W,
  parameter int unsigned IW    = IDX_W,
  parameter int unsigned ELG   = ENT_LG
) (
  input  logic [FRM_W-1:0]        frame,
  input  logic [IW-1:0]           idx,
  output logic [FRM_W+IW+ELG-1:0] ent_addr
);
  // each entry is 2**ELG bytes: base frame, then index scaled by entry size
  assign ent_addr = {frame, idx, {ELG{1'b0}}};
endmodule

// File: rtl/pgwalk_ctl.sv
module pgwalk_ctl
  import pgwalk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     accept,
  input  logic     pg_en,
  input  logic     rd_valid,
  input  logic     present,
  output walk_st_e state_q,
  output logic     rd_issue
);
  walk_st_e state_d;
  logic     issued_q, issued_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept)   state_d = pg_en ? ST_DONE : ST_DIR;
      ST_DIR:   if (rd_valid) state_d = present ? ST_TBL : ST_FAULT;
      ST_TBL:   if (rd_valid) state_d = present ? ST_DONE : ST_FAULT;
      ST_DONE:  state_d = ST_IDLE;
      ST_FAULT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // a fresh state starts with its read not yet sent
  assign issued_d = (state_d == state_q);
  assign rd_issue = ((state_q == ST_DIR) || (state_q == ST_TBL)) && !issued_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      issued_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      issued_q <= issued_d;
    end
  end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_lin,
  input  logic [ADDR_W-1:0] cr_base,
  input  logic              pg_en,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [ADDR_W-1:0] mem_rd_data,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_phys,
  output logic              rsp_fault,
  output logic              rsp_fault_lvl
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  walk_st_e state_q;
  logic     rd_issue, accept, present;

  logic [ADDR_W-1:0]  lin_q, phys_q, phys_d;
  logic [FRAME_W-1:0] base_q, nxt_q;
  logic               lvl_q, lvl_d;
  logic               lin_en, nxt_en, phys_en, lvl_en;
  logic [ADDR_W-1:0]  dir_addr, tbl_addr;

  assign req_ready = (state_q == ST_IDLE) && rst_int_n;
  assign accept    = req_valid && req_ready;
  assign present   = mem_rd_data[PRES_BIT];

  pgwalk_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .accept   (accept),
    .pg_en    (!pg_en),
    .rd_valid (mem_rd_valid),
    .present  (present),
    .state_q  (state_q),
    .rd_issue (rd_issue)
  );

  pgwalk_ent_addr u_dir_addr (
    .frame    (base_q),
    .idx      (lin_q[DIR_LSB +: IDX_W]),
    .ent_addr (dir_addr)
  );

  pgwalk_ent_addr u_tbl_addr (
    .frame    (nxt_q),
    .idx      (lin_q[TBL_LSB +: IDX_W]),
    .ent_addr (tbl_addr)
  );

  // clock enables for the datapath registers
  assign lin_en  = accept;
  assign nxt_en  = (state_q == ST_DIR) && mem_rd_valid;
  assign phys_en = accept || ((state_q == ST_TBL) && mem_rd_valid);
  assign lvl_en  = mem_rd_valid && ((state_q == ST_DIR) || (state_q == ST_TBL));

  always_comb begin
    phys_d = req_lin;
    if (state_q == ST_TBL)
      phys_d = {mem_rd_data[ADDR_W-1:OFF_W], lin_q[OFF_W-1:0]};
  end
  assign lvl_d = (state_q == ST_TBL);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      lin_q  <= '0;
      base_q <= '0;
      nxt_q  <= '0;
      phys_q <= '0;
      lvl_q  <= 1'b0;
    end else begin
      if (lin_en) begin
        lin_q  <= req_lin;
        base_q <= cr_base[ADDR_W-1:OFF_W];
      end
      if (nxt_en)  nxt_q  <= mem_rd_data[ADDR_W-1:OFF_W];
      if (phys_en) phys_q <= phys_d;
      if (lvl_en)  lvl_q  <= lvl_d;
    end
  end

  assign mem_rd_en     = rd_issue;
  assign mem_rd_addr   = (state_q == ST_TBL) ? tbl_addr : dir_addr;
  assign rsp_valid     = (state_q == ST_DONE) || (state_q == ST_FAULT);
  assign rsp_fault     = (state_q == ST_FAULT);
  assign rsp_phys      = (state_q == ST_DONE) ? phys_q : '0;
  assign rsp_fault_lvl = (state_q == ST_FAULT) && lvl_q;
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_lin,
  input logic [31:0] cr_base,
  input logic        pg_en,
  input logic        mem_rd_en,
  input logic [31:0] mem_rd_addr,
  input logic        rsp_valid,
  input logic [31:0] rsp_phys,
  input logic        rsp_fault
);
  a_r1_dir_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && pg_en) |=>
      (mem_rd_en && mem_rd_addr == {$past(cr_base[31:12]), $past(req_lin[31:22]), 2'b00}));

  a_r6_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !pg_en) |=>
      (rsp_valid && !rsp_fault && !mem_rd_en && rsp_phys == $past(req_lin)));

  a_r7_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r8_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r4_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_phys == 32'd0));
endmodule

bind pgwalk_top pgwalk_chk u_pgwalk_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_lin     (req_lin),
  .cr_base     (cr_base),
  .pg_en       (pg_en),
  .mem_rd_en   (mem_rd_en),
  .mem_rd_addr (mem_rd_addr),
  .rsp_valid   (rsp_valid),
  .rsp_phys    (rsp_phys),
  .rsp_fault   (rsp_fault)
);

// File: tb/pgwalk_top_bench.sv
`timescale 1ns/1ps
module pgwalk_top_bench;
  logic        clk, rst_n;
  logic        req_valid, req_ready, pg_en;
  logic [31:0] req_lin, cr_base;
  logic        mem_rd_en, mem_rd_valid;
  logic [31:0] mem_rd_addr, mem_rd_data;
  logic        rsp_valid, rsp_fault, rsp_fault_lvl;
  logic [31:0] rsp_phys;

  int nchk, nfail;

  pgwalk_top u_pgwalk_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_lin(req_lin), .cr_base(cr_base), .pg_en(pg_en),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .rsp_valid(rsp_valid), .rsp_phys(rsp_phys), .rsp_fault(rsp_fault),
    .rsp_fault_lvl(rsp_fault_lvl)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // behavioural memory: sparse image, per-read latency from a queue
  logic [31:0] img [logic [31:0]];
  int          lat_q[$];
  logic [31:0] exp_addr_q[$];
  int          wait_c;
  logic [31:0] rd_addr_l;
  bit          in_walk;

  function automatic logic [31:0] peek(logic [31:0] a);
    return img.exists(a) ? img[a] : 32'd0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rd_valid <= 1'b0;
      mem_rd_data  <= 32'd0;
      wait_c       <= 0;
      rd_addr_l    <= 32'd0;
    end else begin
      mem_rd_valid <= 1'b0;
      if (wait_c == 1) begin
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= peek(rd_addr_l);
      end
      if (wait_c > 0) wait_c <= wait_c - 1;
      if (mem_rd_en) begin
        wait_c    <= (lat_q.size() > 0) ? lat_q.pop_front() : 1;
        rd_addr_l <= mem_rd_addr;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd_en) begin
        if (exp_addr_q.size() == 0)
          check(1'b0, "R7 unexpected read", mem_rd_addr, 32'hffffffff);
        else begin
          logic [31:0] e;
          e = exp_addr_q.pop_front();
          check(mem_rd_addr == e, "R1/R2 read address", mem_rd_addr, e);
        end
      end
      if (!in_walk)
        check(!rsp_valid && !mem_rd_en, "R7/R10 idle quiet", {rsp_valid, mem_rd_en}, 0);
    end
  end

  // one transaction with model-computed expectations
  task automatic walk(input logic [31:0] lin, input logic [31:0] base, input bit en,
                      input int ld, input int lt, input bit disturb);
    logic [31:0] pde, pte, da, ta, exp_phys;
    bit exp_f, exp_l;
    int exp_n, n;
    da = {base[31:12], lin[31:22], 2'b00};
    pde = peek(da);
    ta = {pde[31:12], lin[21:12], 2'b00};
    pte = peek(ta);
    exp_f = 0; exp_l = 0;
    if (!en) begin
      exp_phys = lin; exp_n = 1;
    end else begin
      exp_addr_q.push_back(da); lat_q.push_back(ld);
      if (!pde[0]) begin
        exp_f = 1; exp_phys = 0; exp_n = ld + 3;
      end else begin
        exp_addr_q.push_back(ta); lat_q.push_back(lt);
        if (!pte[0]) begin
          exp_f = 1; exp_l = 1; exp_phys = 0;
        end else exp_phys = {pte[31:12], lin[11:0]};
        exp_n = ld + lt + 5;
      end
    end
    in_walk = 1;
    req_valid = 1; req_lin = lin; cr_base = base; pg_en = en;
    @(posedge clk);
    @(negedge clk);
    check(!req_ready || !en, "R7 ready low after accept", req_ready, 0);
    if (disturb) begin
      req_lin = lin ^ 32'hffc0_0000; cr_base = 32'h00ab_c000; pg_en = ~en;
    end else req_valid = 0;
    n = 1;
    while (!rsp_valid && n < 300) begin
      @(negedge clk); n++;
    end
    check(n == exp_n, "R8 response latency", n, exp_n);
    check(rsp_phys == exp_phys, "R3/R6 physical address", rsp_phys, exp_phys);
    check(rsp_fault == exp_f, "R4/R5 fault flag", rsp_fault, exp_f);
    check(!exp_f || rsp_fault_lvl == exp_l, "R4/R5 fault level", rsp_fault_lvl, exp_l);
    req_valid = 0;
    @(negedge clk);
    check(req_ready && !rsp_valid, "R10 single pulse, ready again", {req_ready, rsp_valid}, 2'b10);
    check(exp_addr_q.size() == 0, "R8 reads issued", exp_addr_q.size(), 0);
    exp_addr_q.delete(); lat_q.delete();
    in_walk = 0;
  endtask

  initial begin
    #400000;
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    nchk = 0; nfail = 0; in_walk = 1;
    rst_n = 0; req_valid = 0; req_lin = 0; cr_base = 0; pg_en = 0;
    // directory at 0x0010_0000; tables at 0x0020_0000 and 0x0030_0000
    img[32'h0010_0000 + (32'h004 << 2)] = 32'h0020_0001;
    img[32'h0010_0000 + (32'h005 << 2)] = 32'h0030_0003;
    img[32'h0010_0000 + (32'h3ff << 2)] = 32'h0020_0000; // not present
    img[32'h0020_0000 + (32'h123 << 2)] = 32'h8765_4001;
    img[32'h0020_0000 + (32'h000 << 2)] = 32'h1111_1ffe; // not present
    img[32'h0030_0000 + (32'h3ff << 2)] = 32'hfffff_001;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(req_ready && !rsp_valid && !mem_rd_en, "R9 reset state",
          {req_ready, rsp_valid, mem_rd_en}, 3'b100);
    in_walk = 0;
    walk(32'h0112_3abc, 32'h0010_0000, 1, 1, 1, 0); // R3 full walk, short latency
    walk(32'h0112_3abc, 32'h0010_0fff, 1, 4, 7, 0); // R1 base low bits ignored
    walk(32'h017f_f123, 32'h0010_0000, 1, 2, 3, 0); // R2 second table
    walk(32'hffc0_0555, 32'h0010_0000, 1, 5, 1, 0); // R4 directory fault
    walk(32'h0100_0777, 32'h0010_0000, 1, 2, 6, 0); // R5 table fault
    walk(32'hdead_beef, 32'h0010_0000, 0, 1, 1, 0); // R6 bypass
    walk(32'h0112_3001, 32'h0010_0000, 1, 3, 2, 1); // R7 R10 disturbed inputs
    walk(32'h1234_5678, 32'h0010_0000, 0, 1, 1, 1); // R6 bypass, disturbed
    walk(32'h0112_3fff, 32'h0010_0000, 1, 9, 12, 0); // R8 long latency
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule